// File: doc/BRIEF.md
# Byte Scan Readout with Cascade Chaining

This block reads a 32-bit snapshot out one byte at a time onto a shared 8-bit bus that can be released to high impedance. A small sequencer selects which byte is presented. It moves one byte toward the most significant end on each falling edge of an external scan strobe, but only while the active-low enable is asserted. A byte is placed on the bus only while the strobe is high. The host therefore sees one pulse of the strobe as a request for the next byte.

After the fourth byte the sequencer enters a terminal state. In that state it releases the bus and pulls its active-low cascade output down. If that output is wired to the enable of a second instance, the second instance takes over the bus on the following strobes. In this way any number of devices share one bus, one strobe and one restart line. Driving the combined restart/load input low does two things in the same clock: it returns the sequencer to the least significant byte, and it captures a fresh copy of the 32-bit input word. The strobe, the restart and the enable are sampled on the system clock.

Top module: `byte_scan_readout`

## Requirements
- R1: After the clock-domain reset, the sequencer selects byte 0, `cascade_n` is high, `bus_oe` is low, and the snapshot is zero.
- R2: A clock edge with `scan_rst_n` low returns the sequencer to byte 0 and captures `data_in` into the snapshot. `cascade_n` is high from the next cycle.
- R3: A falling edge of `scan` is a cycle in which `scan` is low and was high in the previous cycle. Each such edge seen while `en_n` is low moves the selection up by exactly one byte.
- R4: While `en_n` is high, `bus_oe` is low and falling edges of `scan` leave the selection unchanged.
- R5: Once the terminal state is reached (after byte 3), further strobes leave it there and the bus stays released until `scan_rst_n` is driven low.
- R6: `cascade_n` is low exactly while the sequencer is in the terminal state.
- R7: `bus_oe` is high only when `en_n` is low, `scan` is high and the sequencer is not terminal. Selection k (0 to 3) drives `bus_q` with snapshot bits 8k+7 down to 8k. `bus_z` follows `bus_q` when `bus_oe` is high and is high impedance otherwise.
- R8: When a restart and a falling edge of `scan` arrive in the same cycle, the restart wins and the selection is byte 0.
- R9: Three instances share `scan` and `scan_rst_n`, with each enable tied to the previous `cascade_n`. They present 12 bytes in order: the first device's bytes 0 to 3, then the second's, then the third's. After that no instance drives the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| scan | input | 1 | Scan strobe; bus valid while high, advance on falling edge |
| scan_rst_n | input | 1 | Active-low restart to byte 0 plus snapshot load |
| en_n | input | 1 | Active-low enable for sequencer and bus |
| data_in | input | 32 | Word captured into the snapshot on restart |
| bus_q | output | 8 | Selected snapshot byte |
| bus_oe | output | 1 | Bus drive enable |
| bus_z | output | 8 | Tristate bus: bus_q when bus_oe, else high impedance |
| cascade_n | output | 1 | Active-low hand-off to the next device's enable |

## Verification
The assertions assume that `scan`, `scan_rst_n` and `en_n` are synchronous to `clk`. They also assume that `en_n` changes only while the strobe is low, as it does when it is driven from an upstream `cascade_n`. The random stimulus draws a new strobe level and a rare restart every cycle. It lets the enable toggle only in cycles where the strobe is low both before and after the change, so no edge is ever credited to a half-enabled state. Directed sequences then cover the restart colliding with an edge, strobes applied in the terminal state, and a three-device chain.

// File: rtl/byte_scan_readout.sv
module byte_scan_readout #(
  parameter int BW = 8,
  parameter int NB = 4,
  localparam int SW = $clog2(NB + 1),
  localparam int DW = BW * NB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan,
  input  logic          scan_rst_n,
  input  logic          en_n,
  input  logic [DW-1:0] data_in,
  output logic [BW-1:0] bus_q,
  output logic          bus_oe,
  output logic [BW-1:0] bus_z,
  output logic          cascade_n
);

  logic [SW-1:0] st;
  logic [DW-1:0] snap;
  logic          scan_d;

  wire fall = scan_d & ~scan;
  wire last = (st == SW'(NB));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= '0;
      snap   <= '0;
      scan_d <= 1'b0;
    end else begin
      scan_d <= scan;
      if (!scan_rst_n) begin
        st   <= '0;
        snap <= data_in;
      end else if (fall && !en_n && !last) begin
        st <= st + 1'b1;
      end
    end
  end

  assign cascade_n = ~last;
  assign bus_oe    = ~en_n & scan & ~last;
  assign bus_q     = BW'(snap >> (BW * int'(st)));
  assign bus_z     = bus_oe ? bus_q : {BW{1'bz}};

endmodule

module byte_scan_readout_chk #(
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scan,
  input logic          scan_rst_n,
  input logic          en_n,
  input logic          bus_oe,
  input logic          cascade_n,
  input logic [SW-1:0] st
);

  // R2
  restart_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_rst_n |=> (st == '0) && cascade_n);

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_rst_n |=> (st == $past(st)) || (st == $past(st) + 1'b1));

  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n && scan_rst_n |=> $stable(st));

  // R5
  terminal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cascade_n && scan_rst_n |=> !cascade_n);

  // R7
  drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> scan && !en_n && cascade_n);

endmodule

bind byte_scan_readout byte_scan_readout_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scan(scan), .scan_rst_n(scan_rst_n),
  .en_n(en_n), .bus_oe(bus_oe), .cascade_n(cascade_n), .st(st)
);

// File: tb/tb_byte_scan_readout.sv
module tb_byte_scan_readout;
  logic clk = 0, rst_n = 0, scan = 0, srst_n = 1, en_n = 0;
  logic [31:0] din = 0, d1 = 0, d2 = 0;
  logic [7:0] q0, q1, q2, z0, z1, z2;
  logic oe0, oe1, oe2, c0, c1, c2;
  int checks = 0, bad = 0;
  int ms = 0;
  logic [31:0] msnap = 0;
  logic mprev = 0;

  always #2 clk = ~clk;

  byte_scan_readout dut (.clk(clk), .rst_n(rst_n), .scan(scan), .scan_rst_n(srst_n),
    .en_n(en_n), .data_in(din), .bus_q(q0), .bus_oe(oe0), .bus_z(z0), .cascade_n(c0));
  byte_scan_readout u1 (.clk(clk), .rst_n(rst_n), .scan(scan), .scan_rst_n(srst_n),
    .en_n(c0), .data_in(d1), .bus_q(q1), .bus_oe(oe1), .bus_z(z1), .cascade_n(c1));
  byte_scan_readout u2 (.clk(clk), .rst_n(rst_n), .scan(scan), .scan_rst_n(srst_n),
    .en_n(c1), .data_in(d2), .bus_q(q2), .bus_oe(oe2), .bus_z(z2), .cascade_n(c2));

  function automatic logic exp_oe(logic e, logic s, int st);
    return !e && s && st != 4;
  endfunction

  function automatic logic [7:0] exp_byte(logic [31:0] w, int st);
    return w[st*8 +: 8];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(logic s, logic r, logic e, logic [31:0] d);
    @(negedge clk);
    scan = s; srst_n = r; en_n = e; din = d;
    #1;
    chk("R6 cascade", 32'(c0), 32'(ms != 4));
    chk("R7 oe", 32'(oe0), 32'(exp_oe(e, s, ms)));
    if (exp_oe(e, s, ms)) chk("R7 byte", 32'(q0), 32'(exp_byte(msnap, ms)));
    @(posedge clk);
    if (!r) begin ms = 0; msnap = d; end
    else if (mprev && !s && !e && ms != 4) ms++;
    mprev = s;
  endtask

  task automatic run();
    logic s, e, r;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    // R1
    chk("R1 cascade", 32'(c0), 32'd1);
    chk("R1 oe", 32'(oe0), 32'd0);
    scan = 1; #1;
    chk("R1 byte0 zero", 32'(q0), 32'd0);
    scan = 0;
    @(posedge clk); mprev = 0;
    // R2 load and walk R3
    cyc(0, 0, 0, 32'hA1B2C3D4);
    for (int k = 0; k < 4; k++) begin
      cyc(1, 1, 0, 32'h0);
      chk("R2 R3 byte order", 32'(q0), 32'(exp_byte(32'hA1B2C3D4, k)));
      cyc(0, 1, 0, 32'h0);
    end
    // R5 terminal holds
    for (int k = 0; k < 3; k++) begin
      cyc(1, 1, 0, 32'h0);
      chk("R5 bus released", 32'(oe0), 32'd0);
      cyc(0, 1, 0, 32'h0);
      chk("R5 terminal", 32'(c0), 32'd0);
    end
    // R8 restart beats coincident fall
    cyc(0, 0, 0, 32'h11223344);
    cyc(1, 1, 0, 32'h0);
    cyc(0, 0, 0, 32'h55667788);
    cyc(1, 1, 0, 32'h0);
    chk("R8 restart wins", 32'(q0), 32'h88);
    // R4 disabled: no advance, bus off
    cyc(0, 1, 0, 32'h0);
    cyc(0, 1, 1, 32'h0);
    for (int k = 0; k < 3; k++) begin
      cyc(1, 1, 1, 32'h0);
      chk("R4 bus off", 32'(oe0), 32'd0);
      cyc(0, 1, 1, 32'h0);
    end
    cyc(0, 1, 0, 32'h0);
    cyc(1, 1, 0, 32'h0);
    chk("R4 selection kept", 32'(q0), 32'h77);
    // random
    s = 1; e = 0;
    for (int i = 0; i < 4000; i++) begin
      logic ns;
      ns = 1'($urandom_range(0, 1));
      r = ($urandom_range(0, 29) != 0);
      if (!s && !ns && $urandom_range(0, 3) == 0) e = ~e;
      cyc(ns, r, e, $urandom);
      s = ns;
    end
    // R9 chain
    d1 = 32'h0F1E2D3C; d2 = 32'h4B5A6978;
    cyc(0, 0, 0, 32'h90817263);
    cyc(0, 1, 0, 32'h0);
    for (int k = 0; k < 12; k++) begin
      logic [31:0] w;
      @(negedge clk); scan = 1; #1;
      w = (k < 4) ? 32'h90817263 : (k < 8) ? d1 : d2;
      chk("R9 one driver", 32'(oe0) + 32'(oe1) + 32'(oe2), 32'd1);
      chk("R9 chain byte", 32'(oe0 ? q0 : oe1 ? q1 : q2), 32'(exp_byte(w, k % 4)));
      @(negedge clk); scan = 0;
      @(negedge clk);
    end
    @(negedge clk); scan = 1; #1;
    chk("R9 idle after 12", 32'(oe0) + 32'(oe1) + 32'(oe2), 32'd0);
    chk("R9 last cascade", 32'(c2), 32'd0);
    @(negedge clk); scan = 0;
  endtask

  initial begin
    process::self().srandom(32'd17);
    fork
      run();
      begin
        repeat (100000) @(posedge clk);
        bad++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule